// File: doc/BRIEF.md
# Signed-Digit to Two's-Complement Converter

This block takes an N-digit signed-digit operand, where every digit is +1, 0 or -1, and turns it into an ordinary two's-complement word of N+1 bits. Arithmetic in the signed-digit form has no carry chain, so the only carry or borrow chain is paid once, here, when a result leaves the redundant domain.

Each digit arrives as a pair of bits. The conversion is treated as borrow resolution. A -1 digit is the only position that creates a borrow. A 0 digit passes an incoming borrow on. A +1 digit absorbs it. A Kogge-Stone prefix network resolves these per-position generate/propagate pairs in log2(N) levels. Each result bit is then the local digit difference XORed with the borrow arriving at that position. An operand with few -1 digits therefore produces few generate events.

Both a combinational result and a registered copy are provided. The registered copy has a valid flag that trails the input valid by one clock.

Top module: `rb2bin_conv`

## Requirements
- R1: Digit i is encoded by the pair {pos_i[i], neg_i[i]}: 2'b10 is +1, 2'b00 is 0 and 2'b01 is -1. The pair 2'b11 is illegal.
- R2: For legal digits, comb_o equals the sum of digit_i * 2^i, written as an (N+1)-bit two's-complement word.
- R3: comb_o[N] (the sign) is 1 exactly when the value formed by the neg_i bits, read as an unsigned word, is larger than the value formed by the pos_i bits.
- R4: When no digit is -1, comb_o equals pos_i with a zero bit added on top, because no borrow arises.
- R5: comb_illegal_o is 1 exactly when at least one digit pair is 2'b11. For such inputs, comb_o still equals the pos_i word minus the neg_i word.
- R6: One clock edge after valid_i is sampled high, res_o and illegal_o hold the comb_o and comb_illegal_o values seen at that edge. valid_o equals valid_i delayed by one clock.
- R7: While valid_i is low at a clock edge, res_o and illegal_o keep their previous values.
- R8: While rst_ni is low, valid_o, res_o and illegal_o are 0.
- R9: An operand of all -1 digits gives -(2^N-1). An operand of all +1 digits gives 2^N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand is valid; loads the output register |
| pos_i | input | N_DIGITS | Positive bit of each digit pair |
| neg_i | input | N_DIGITS | Negative bit of each digit pair |
| comb_o | output | N_DIGITS+1 | Combinational two's-complement result |
| comb_illegal_o | output | 1 | Combinational flag: a digit pair is 2'b11 |
| res_o | output | N_DIGITS+1 | Registered result |
| illegal_o | output | 1 | Registered illegal flag |
| valid_o | output | 1 | Registered valid, one clock after valid_i |

## Verification
The combinational outputs settle in the same cycle as the operand. The bench drives each operand on the falling edge and compares comb_o and comb_illegal_o a short delay later, before the next rising edge. The registered outputs are due at the rising edge that follows. The bench's model updates its expected register contents once per cycle, only when valid was driven high, and compares res_o, illegal_o and valid_o at the next falling edge, before it drives the next operand. Idle cycles with valid low are mixed in, so the hold behaviour is checked against the model.

// File: rtl/rb2bin_pkg.sv
package rb2bin_pkg;
  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_NEG  = 2'b01;
  localparam logic [1:0] DIG_POS  = 2'b10;
  localparam logic [1:0] DIG_BAD  = 2'b11;

  typedef struct packed {
    logic g;  // borrow created here
    logic p;  // incoming borrow passed on
  } gp_t;
endpackage

// File: rtl/rb_digit_gp.sv
module rb_digit_gp
  import rb2bin_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]      pos_i,
  input  logic [N-1:0]      neg_i,
  output gp_t  [N-1:0]      gp_o,
  output logic [N-1:0]      diff_o,
  output logic              bad_o
);
  logic [N-1:0] bad_bits;

  for (genvar i = 0; i < N; i++) begin : g_dig
    always_comb begin
      unique case ({pos_i[i], neg_i[i]})
        DIG_POS:  begin gp_o[i] = '{g: 1'b0, p: 1'b0}; diff_o[i] = 1'b1; bad_bits[i] = 1'b0; end
        DIG_NEG:  begin gp_o[i] = '{g: 1'b1, p: 1'b0}; diff_o[i] = 1'b1; bad_bits[i] = 1'b0; end
        DIG_ZERO: begin gp_o[i] = '{g: 1'b0, p: 1'b1}; diff_o[i] = 1'b0; bad_bits[i] = 1'b0; end
        default:  begin gp_o[i] = '{g: 1'b0, p: 1'b1}; diff_o[i] = 1'b0; bad_bits[i] = 1'b1; end
      endcase
    end
  end

  assign bad_o = |bad_bits;
endmodule

// File: rtl/rb_prefix_ks.sv
module rb_prefix_ks
  import rb2bin_pkg::*;
#(
  parameter int N = 16
) (
  input  gp_t  [N-1:0] gp_i,
  output logic [N-1:0] bin_o,
  output logic         bout_o
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] g_l [LVLS+1];
  logic [N-1:0] p_l [LVLS+1];

  for (genvar i = 0; i < N; i++) begin : g_in
    assign g_l[0][i] = gp_i[i].g;
    assign p_l[0][i] = gp_i[i].p;
  end

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign g_l[k+1][i] = g_l[k][i] | (p_l[k][i] & g_l[k][i-D]);
        assign p_l[k+1][i] = p_l[k][i] & p_l[k][i-D];
      end else begin : g_pass
        assign g_l[k+1][i] = g_l[k][i];
        assign p_l[k+1][i] = p_l[k][i];
      end
    end
  end

  // group generate over [i:0] is the borrow into i+1; no borrow into bit 0
  assign bin_o  = {g_l[LVLS][N-2:0], 1'b0};
  assign bout_o = g_l[LVLS][N-1];
endmodule

// File: rtl/rb2bin_oreg.sv
module rb2bin_oreg #(
  parameter int W       = 17,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] res_i,
  input  logic         bad_i,
  output logic [W-1:0] res_o,
  output logic         bad_o,
  output logic         valid_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        res_o   <= '0;
        bad_o   <= 1'b0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          res_o <= res_i;
          bad_o <= bad_i;
        end
      end
    end
  end else begin : g_thru
    assign valid_o = valid_i;
    assign res_o   = res_i;
    assign bad_o   = bad_i;
  end
endmodule

// File: rtl/rb2bin_conv.sv
module rb2bin_conv
  import rb2bin_pkg::*;
#(
  parameter int N_DIGITS = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [N_DIGITS-1:0] pos_i,
  input  logic [N_DIGITS-1:0] neg_i,
  output logic [N_DIGITS:0]   comb_o,
  output logic                comb_illegal_o,
  output logic [N_DIGITS:0]   res_o,
  output logic                illegal_o,
  output logic                valid_o
);
  localparam int W = N_DIGITS + 1;

  gp_t  [N_DIGITS-1:0] gp;
  logic [N_DIGITS-1:0] diff;
  logic [N_DIGITS-1:0] bin;
  logic                bout;

  rb_digit_gp #(.N(N_DIGITS)) u_dig (
    .pos_i (pos_i),
    .neg_i (neg_i),
    .gp_o  (gp),
    .diff_o(diff),
    .bad_o (comb_illegal_o)
  );

  rb_prefix_ks #(.N(N_DIGITS)) u_pfx (
    .gp_i  (gp),
    .bin_o (bin),
    .bout_o(bout)
  );

  assign comb_o = {bout, diff ^ bin};

  rb2bin_oreg #(.W(W), .REG_OUT(REG_OUT)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .res_i  (comb_o),
    .bad_i  (comb_illegal_o),
    .res_o  (res_o),
    .bad_o  (illegal_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/rb2bin_conv_chk.sv
module rb2bin_conv_chk #(
  parameter int N_DIGITS = 16,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [N_DIGITS-1:0] pos_i,
  input logic [N_DIGITS-1:0] neg_i,
  input logic [N_DIGITS:0]   comb_o,
  input logic                comb_illegal_o,
  input logic [N_DIGITS:0]   res_o,
  input logic                illegal_o,
  input logic                valid_o
);
  AST_SIGN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comb_o[N_DIGITS] == (neg_i > pos_i)); // R3

  AST_NO_NEG_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_i == '0) |-> (comb_o == {1'b0, pos_i})); // R4

  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comb_illegal_o == ((pos_i & neg_i) != '0)); // R5

  if (REG_OUT) begin : g_reg_chk
    AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R6

    AST_LOAD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (res_o == $past(comb_o)) && (illegal_o == $past(comb_illegal_o))); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(res_o) && $stable(illegal_o) && !valid_o); // R7
  end
endmodule

bind rb2bin_conv rb2bin_conv_chk #(.N_DIGITS(N_DIGITS), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_rb2bin_conv.sv
`timescale 1ns/1ps
module tb_rb2bin_conv;
  localparam int N = 16;
  localparam int W = N + 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [N-1:0] pos_i = '0;
  logic [N-1:0] neg_i = '0;
  logic [W-1:0] comb_o, res_o;
  logic         comb_illegal_o, illegal_o, valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model of the registered stage
  logic [W-1:0] m_res = '0;
  logic         m_ill = 1'b0;
  logic         m_vld = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rb2bin_conv #(.N_DIGITS(N), .REG_OUT(1'b1)) dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_val(input logic [N-1:0] p, input logic [N-1:0] n);
    longint v;
    v = longint'(p) - longint'(n);
    return v[W-1:0];
  endfunction

  // compare registered outputs from the previous edge, then drive a new operand
  task automatic step(input logic [N-1:0] p, input logic [N-1:0] n, input logic v, input string req);
    logic [W-1:0] e;
    @(negedge clk_i);
    chk("R6 valid_o", W'(valid_o), W'(m_vld));
    chk(m_vld ? "R6 res_o" : "R7 res_o hold", res_o, m_res);
    chk(m_vld ? "R6 illegal_o" : "R7 illegal_o hold", W'(illegal_o), W'(m_ill));
    pos_i = p; neg_i = n; valid_i = v;
    #1;
    e = ref_val(p, n);
    chk({req, " comb_o"}, comb_o, e);
    chk("R3 sign", W'(comb_o[N]), W'(n > p));
    chk("R5 illegal flag", W'(comb_illegal_o), W'((p & n) != '0));
    if (n == '0) chk("R4 no borrow", comb_o, {1'b0, p});
    m_vld = v;
    if (v) begin
      m_res = e;
      m_ill = (p & n) != '0;
    end
  endtask

  function automatic void rnd_legal(output logic [N-1:0] p, output logic [N-1:0] n, input int neg_pct);
    p = '0; n = '0;
    for (int i = 0; i < N; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < neg_pct) n[i] = 1'b1;
      else if (r < neg_pct + (100 - neg_pct) / 2) p[i] = 1'b1;
    end
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] p, n;
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid_o", W'(valid_o), '0);
    chk("R8 reset res_o", res_o, '0);
    chk("R8 reset illegal_o", W'(illegal_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 extremes, R1 single digits
    step('1, '0, 1'b1, "R9 all +1");
    step('0, '1, 1'b1, "R9 all -1");
    chk("R9 all -1 value", comb_o, {1'b1, {(N-1){1'b0}}, 1'b1});
    step('0, '0, 1'b1, "R1 all zero");
    step(16'h0001, '0, 1'b1, "R1 plus one");
    step('0, 16'h0001, 1'b1, "R1 minus one");
    step(16'h5555, 16'hAAAA, 1'b1, "R2 alternating +-");
    step(16'hAAAA, 16'h5555, 1'b1, "R2 alternating -+");
    step(16'h0000, 16'h5555, 1'b1, "R2 alternating -1/0");
    step(16'h8000, 16'h7FFF, 1'b1, "R2 long borrow chain");
    step(16'h0001, 16'h8000, 1'b1, "R3 top negative");
    // R5 illegal pairs
    step(16'h0010, 16'h0010, 1'b1, "R5 one bad pair");
    step('1, '1, 1'b1, "R5 all bad");
    // R7 hold across idle
    step(16'h1234, 16'h0042, 1'b0, "R7 idle operand");
    step(16'h00FF, 16'h0F00, 1'b0, "R7 idle operand");
    step(16'h0F0F, 16'h00F0, 1'b1, "R2 after idle");

    for (int k = 0; k < 400; k++) begin
      rnd_legal(p, n, (k % 4) * 15);
      step(p, n, ($urandom_range(3) != 0), "R2 random");
    end
    for (int k = 0; k < 40; k++) begin
      p = 16'($urandom); n = 16'($urandom);
      step(p, n, 1'b1, "R5 random raw");
    end
    step('0, '0, 1'b0, "R7 drain");
    step('0, '0, 1'b0, "R7 drain");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule